// File: doc/BRIEF.md
# Load/Store Address Generator

This block forms the memory address of a load or store and the value that goes back into the base register. It takes a base register value, the program counter, an immediate and a register operand, together with control bits that pick the offset source, the offset direction, pre- or post-indexing, a writeback request, PC-relative mode and an unprivileged-access flag. The register operand may first pass through a barrel shifter. That shifter offers left, logical right, arithmetic right, rotate, and a one-bit rotate through the carry flag.

The address is formed from the base and the offset, added or subtracted, with wraparound. Pre-indexed accesses use that sum. Post-indexed accesses use the untouched base. When writeback is enabled, the base register always receives the sum. The block also gives the address of the second word of a doubleword access. Every result is registered. A request presented with `in_valid` gives its results one clock later with `out_valid` high.

Top module: `agu_addr_gen`

## Requirements
- R1: While reset is held and in the first cycle after it, `out_valid` and `wb_en` are 0.
- R2: The offset address is base plus offset when `add_en`=1 and base minus offset when `add_en`=0, taken modulo 2^32.
- R3: With `pre_index`=1 the access address is the offset address. With `pre_index`=0 it is the unmodified base.
- R4: `wb_value` is always the offset address, whichever indexing form is used. `wb_en` is 1 exactly when the request had `wb_req`=1 (or `unpriv`=1), `cond_pass`=1 and `pc_rel`=0.
- R5: A request with `cond_pass`=0 still produces the addresses, but `wb_en` stays 0.
- R6: With `pc_rel`=1 the base is `pc_val` with its two low bits cleared. `wb_en` is then 0.
- R7: When `off_sel`[1]=1 the offset is `reg_val` shifted by `shift_amt` according to `shift_type`. The codes are 00 left, 01 logical right, 10 arithmetic right and 11 rotate right. For the two right shifts an amount of 0 means 32. A rotate by 0 leaves the value unchanged.
- R8: With `shift_rrx`=1 and `off_sel`[1]=1 the offset is `reg_val` rotated right by one bit, with `carry_in` entering the top bit. `shift_type` and `shift_amt` are then ignored.
- R9: With `unpriv`=1 the access is post-indexed: the access address is the base, whatever `pre_index` says. Writeback is requested, whatever `wb_req` says.
- R10: `acc_addr_hi` equals `acc_addr` + 4 modulo 2^32.
- R11: `out_valid` is `in_valid` delayed by one cycle. Without `in_valid` the address outputs keep their previous values.
- R12: `off_sel`=00 takes `imm_val` as the offset and `off_sel`=01 takes `reg_val` unshifted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request present |
| cond_pass | input | 1 | Condition of the instruction passed |
| base_val | input | 32 | Base register value |
| pc_val | input | 32 | Program counter value |
| imm_val | input | 32 | Immediate offset |
| reg_val | input | 32 | Register offset before shifting |
| off_sel | input | 2 | Offset source: 00 imm, 01 reg, 1x shifted reg |
| shift_type | input | 2 | Shift kind: 00 LSL, 01 LSR, 10 ASR, 11 ROR |
| shift_rrx | input | 1 | Rotate right by one through carry |
| shift_amt | input | 5 | Shift amount |
| carry_in | input | 1 | Current carry flag |
| add_en | input | 1 | 1 add offset, 0 subtract |
| pre_index | input | 1 | 1 pre-indexed, 0 post-indexed |
| wb_req | input | 1 | Base writeback requested |
| pc_rel | input | 1 | Use word-aligned PC as base |
| unpriv | input | 1 | Unprivileged form (forced post-index with writeback) |
| out_valid | output | 1 | Results valid |
| acc_addr | output | 32 | Access address |
| acc_addr_hi | output | 32 | Second-word address (access + 4) |
| wb_value | output | 32 | Value for the base register |
| wb_en | output | 1 | Base register write strobe |

## Verification
The bench sweeps every shift kind over every amount with values whose top bit is set and values whose top bit is clear. This catches a right shift by 0 that is treated as no shift instead of a shift by 32, a rotate that is off by one, and a rotate-through-carry that drops the carry. Sums that wrap past zero in both directions expose an adder cut to the wrong width. All sixteen combinations of add, index, writeback and condition are run. They would show a post-indexed access that used the sum, or a writeback that carried the access address, or a strobe that ignored the condition. PC-relative requests with an unaligned PC, and unprivileged requests that claim pre-indexing without writeback, would show a base that was not masked, or a missing forced post-index.

// File: rtl/agu_pkg.sv
package agu_pkg;

   typedef enum logic [1:0] {
      SH_LSL = 2'b00,
      SH_LSR = 2'b01,
      SH_ASR = 2'b10,
      SH_ROR = 2'b11
   } shift_kind_e;

   typedef enum logic [1:0] {
      OFS_IMM     = 2'b00,
      OFS_REG     = 2'b01,
      OFS_SHIFTED = 2'b10,
      OFS_SHIFT2  = 2'b11
   } ofs_src_e;

endpackage

// File: rtl/agu_shifter.sv
module agu_shifter #(
   parameter int  DATA_W      = 32,
   parameter bit  HAS_SHIFTER = 1'b1,
   localparam int AMT_W       = $clog2(DATA_W)
) (
   input  logic [DATA_W-1:0]       val_i,
   input  agu_pkg::shift_kind_e    kind_i,
   input  logic                    rrx_i,
   input  logic [AMT_W-1:0]        amt_i,
   input  logic                    carry_i,
   output logic [DATA_W-1:0]       res_o
);
   import agu_pkg::*;

   localparam logic [AMT_W:0] FULL_AMT = (AMT_W+1)'(DATA_W);

   generate
      if (HAS_SHIFTER) begin : g_shift
         logic [AMT_W:0]  n_eff;
         logic [AMT_W:0]  n_back;

         // right shifts encode a full-width shift as amount zero
         always_comb begin
            if ((amt_i == '0) && ((kind_i == SH_LSR) || (kind_i == SH_ASR)))
               n_eff = FULL_AMT;
            else
               n_eff = {1'b0, amt_i};
            n_back = FULL_AMT - {1'b0, amt_i};
         end

         always_comb begin
            if (rrx_i) begin
               res_o = {carry_i, val_i[DATA_W-1:1]};
            end else begin
               unique case (kind_i)
                  SH_LSL:  res_o = val_i << n_eff;
                  SH_LSR:  res_o = val_i >> n_eff;
                  SH_ASR:  res_o = DATA_W'($signed(val_i) >>> n_eff);
                  default: res_o = (val_i >> n_eff) | (val_i << n_back);
               endcase
            end
         end
      end else begin : g_pass
         logic unused_shift;
         assign unused_shift = ^{kind_i, rrx_i, amt_i, carry_i};
         assign res_o = val_i;
      end
   endgenerate

endmodule

// File: rtl/agu_offset_calc.sv
module agu_offset_calc #(
   parameter int DATA_W     = 32,
   parameter int PC_ALIGN   = 2,
   parameter int DWORD_STEP = 4
) (
   input  logic [DATA_W-1:0] base_i,
   input  logic [DATA_W-1:0] pc_i,
   input  logic [DATA_W-1:0] ofs_i,
   input  logic              add_i,
   input  logic              pre_i,
   input  logic              pc_rel_i,
   input  logic              unpriv_i,
   input  logic              cond_i,
   input  logic              wb_req_i,
   output logic [DATA_W-1:0] acc_o,
   output logic [DATA_W-1:0] acc_hi_o,
   output logic [DATA_W-1:0] wb_val_o,
   output logic              wb_en_o
);

   localparam logic [DATA_W-1:0] STEP = DATA_W'(DWORD_STEP);

   logic [DATA_W-1:0] pc_word;
   logic [DATA_W-1:0] base_eff;
   logic [DATA_W-1:0] sum;
   logic              use_sum;

   generate
      if (PC_ALIGN > 0) begin : g_align
         assign pc_word = {pc_i[DATA_W-1:PC_ALIGN], {PC_ALIGN{1'b0}}};
      end else begin : g_noalign
         assign pc_word = pc_i;
      end
   endgenerate

   assign base_eff = pc_rel_i ? pc_word : base_i;
   assign sum      = add_i ? (base_eff + ofs_i) : (base_eff - ofs_i);
   // unprivileged forms are always post-indexed
   assign use_sum  = pre_i & ~unpriv_i;
   assign acc_o    = use_sum ? sum : base_eff;
   assign acc_hi_o = (use_sum ? sum : base_eff) + STEP;
   assign wb_val_o = sum;
   assign wb_en_o  = cond_i & (wb_req_i | unpriv_i) & ~pc_rel_i;

endmodule

// File: rtl/agu_out_stage.sv
module agu_out_stage #(
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              vld_i,
   input  logic [DATA_W-1:0] acc_i,
   input  logic [DATA_W-1:0] acc_hi_i,
   input  logic [DATA_W-1:0] wb_val_i,
   input  logic              wb_en_i,
   output logic              vld_o,
   output logic [DATA_W-1:0] acc_o,
   output logic [DATA_W-1:0] acc_hi_o,
   output logic [DATA_W-1:0] wb_val_o,
   output logic              wb_en_o
);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         vld_o   <= 1'b0;
         wb_en_o <= 1'b0;
      end else begin
         vld_o   <= vld_i;
         wb_en_o <= vld_i & wb_en_i;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         acc_o    <= '0;
         acc_hi_o <= '0;
         wb_val_o <= '0;
      end else if (vld_i) begin
         acc_o    <= acc_i;
         acc_hi_o <= acc_hi_i;
         wb_val_o <= wb_val_i;
      end
   end

endmodule

// File: rtl/agu_addr_gen.sv
module agu_addr_gen #(
   parameter int  DATA_W      = 32,
   parameter int  PC_ALIGN    = 2,
   parameter int  DWORD_STEP  = 4,
   parameter bit  HAS_SHIFTER = 1'b1,
   localparam int AMT_W       = $clog2(DATA_W)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic              cond_pass,
   input  logic [DATA_W-1:0] base_val,
   input  logic [DATA_W-1:0] pc_val,
   input  logic [DATA_W-1:0] imm_val,
   input  logic [DATA_W-1:0] reg_val,
   input  logic [1:0]        off_sel,
   input  logic [1:0]        shift_type,
   input  logic              shift_rrx,
   input  logic [AMT_W-1:0]  shift_amt,
   input  logic              carry_in,
   input  logic              add_en,
   input  logic              pre_index,
   input  logic              wb_req,
   input  logic              pc_rel,
   input  logic              unpriv,
   output logic              out_valid,
   output logic [DATA_W-1:0] acc_addr,
   output logic [DATA_W-1:0] acc_addr_hi,
   output logic [DATA_W-1:0] wb_value,
   output logic              wb_en
);
   import agu_pkg::*;

   localparam logic [DATA_W-1:0] PC_KEEP = ~DATA_W'((64'd1 << PC_ALIGN) - 64'd1);
   localparam logic [DATA_W-1:0] STEP    = DATA_W'(DWORD_STEP);

   generate
      if ((DATA_W < 8) || ((DATA_W & (DATA_W - 1)) != 0)) begin : g_bad_width
         $error("agu_addr_gen: DATA_W must be a power of two of at least 8");
      end
      if ((PC_ALIGN < 0) || (PC_ALIGN >= DATA_W)) begin : g_bad_align
         $error("agu_addr_gen: PC_ALIGN out of range");
      end
      if (DWORD_STEP <= 0) begin : g_bad_step
         $error("agu_addr_gen: DWORD_STEP must be positive");
      end
   endgenerate

   logic [DATA_W-1:0] shifted;
   logic [DATA_W-1:0] offset;
   logic [DATA_W-1:0] acc_n;
   logic [DATA_W-1:0] acc_hi_n;
   logic [DATA_W-1:0] wb_val_n;
   logic              wb_en_n;

   agu_shifter #(.DATA_W(DATA_W), .HAS_SHIFTER(HAS_SHIFTER)) u_shift (
      .val_i   (reg_val),
      .kind_i  (shift_kind_e'(shift_type)),
      .rrx_i   (shift_rrx),
      .amt_i   (shift_amt),
      .carry_i (carry_in),
      .res_o   (shifted)
   );

   always_comb begin
      unique case (ofs_src_e'(off_sel))
         OFS_IMM: offset = imm_val;
         OFS_REG: offset = reg_val;
         default: offset = shifted;
      endcase
   end

   agu_offset_calc #(.DATA_W(DATA_W), .PC_ALIGN(PC_ALIGN), .DWORD_STEP(DWORD_STEP)) u_calc (
      .base_i   (base_val),
      .pc_i     (pc_val),
      .ofs_i    (offset),
      .add_i    (add_en),
      .pre_i    (pre_index),
      .pc_rel_i (pc_rel),
      .unpriv_i (unpriv),
      .cond_i   (cond_pass),
      .wb_req_i (wb_req),
      .acc_o    (acc_n),
      .acc_hi_o (acc_hi_n),
      .wb_val_o (wb_val_n),
      .wb_en_o  (wb_en_n)
   );

   agu_out_stage #(.DATA_W(DATA_W)) u_out (
      .clk      (clk),
      .rst_n    (rst_n),
      .vld_i    (in_valid),
      .acc_i    (acc_n),
      .acc_hi_i (acc_hi_n),
      .wb_val_i (wb_val_n),
      .wb_en_i  (wb_en_n),
      .vld_o    (out_valid),
      .acc_o    (acc_addr),
      .acc_hi_o (acc_addr_hi),
      .wb_val_o (wb_value),
      .wb_en_o  (wb_en)
   );

   // ---------------- assertions ----------------
   p_add_imm_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $past(in_valid && pre_index && !pc_rel && !unpriv && off_sel == 2'b00 && add_en)
      |-> acc_addr == $past(base_val) + $past(imm_val));

   p_post_base_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $past(in_valid && !pre_index && !pc_rel) |-> acc_addr == $past(base_val));

   p_wb_value_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $past(in_valid && pre_index && !unpriv) |-> wb_value == acc_addr);

   p_wb_cond_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $past(in_valid && !cond_pass) |-> !wb_en);

   p_pc_align_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $past(in_valid && pc_rel && !pre_index) |-> acc_addr == ($past(pc_val) & PC_KEEP));

   p_pc_nowb_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $past(in_valid && pc_rel) |-> !wb_en);

   p_rrx_carry_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $past(in_valid && pre_index && add_en && !pc_rel && !unpriv && off_sel[1] && shift_rrx
            && base_val == '0) |-> acc_addr[DATA_W-1] == $past(carry_in));

   p_unpriv_r9: assert property (@(posedge clk) disable iff (!rst_n)
      $past(in_valid && unpriv && cond_pass && !pc_rel) |-> wb_en && acc_addr == $past(base_val));

   p_hi_step_r10: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> acc_addr_hi == acc_addr + STEP);

   p_valid_lat_r11: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid == $past(in_valid));

   p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
      $past(!in_valid) && $past(rst_n) |-> $stable(acc_addr) && !wb_en);

endmodule

// File: tb/sim_agu_addr_gen.sv
`timescale 1ns/1ps
module sim_agu_addr_gen;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic        cond_pass = 1'b0;
   logic [31:0] base_val = '0;
   logic [31:0] pc_val = '0;
   logic [31:0] imm_val = '0;
   logic [31:0] reg_val = '0;
   logic [1:0]  off_sel = '0;
   logic [1:0]  shift_type = '0;
   logic        shift_rrx = 1'b0;
   logic [4:0]  shift_amt = '0;
   logic        carry_in = 1'b0;
   logic        add_en = 1'b0;
   logic        pre_index = 1'b0;
   logic        wb_req = 1'b0;
   logic        pc_rel = 1'b0;
   logic        unpriv = 1'b0;
   logic        out_valid;
   logic [31:0] acc_addr;
   logic [31:0] acc_addr_hi;
   logic [31:0] wb_value;
   logic        wb_en;

   int n_tests = 0;
   int n_fail  = 0;
   bit done    = 1'b0;

   always #2.5 clk = ~clk;

   agu_addr_gen u0 (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .cond_pass(cond_pass),
      .base_val(base_val), .pc_val(pc_val), .imm_val(imm_val), .reg_val(reg_val),
      .off_sel(off_sel), .shift_type(shift_type), .shift_rrx(shift_rrx),
      .shift_amt(shift_amt), .carry_in(carry_in), .add_en(add_en),
      .pre_index(pre_index), .wb_req(wb_req), .pc_rel(pc_rel), .unpriv(unpriv),
      .out_valid(out_valid), .acc_addr(acc_addr), .acc_addr_hi(acc_addr_hi),
      .wb_value(wb_value), .wb_en(wb_en)
   );

   task automatic check(input bit ok, input string tag, input logic [31:0] act,
                        input logic [31:0] exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   function automatic logic [31:0] ref_shift(input logic [31:0] v, input logic [1:0] k,
                                             input logic rrx, input logic [4:0] a,
                                             input logic c);
      logic [63:0] t;
      int          n;
      n = (a == 5'd0) ? 32 : int'(a);
      if (rrx) return {c, v[31:1]};
      case (k)
         2'd0: return v << a;
         2'd1: begin t = {32'd0, v} >> n; return t[31:0]; end
         2'd2: begin t = {{32{v[31]}}, v} >> n; return t[31:0]; end
         default: begin t = {v, v} >> a; return t[31:0]; end
      endcase
   endfunction

   // drive one request from the current input values and compare all outputs
   task automatic fire(input string tag);
      logic [31:0] ofs, b, sum, acc;
      logic        wbe;
      case (off_sel)
         2'd0: ofs = imm_val;
         2'd1: ofs = reg_val;
         default: ofs = ref_shift(reg_val, shift_type, shift_rrx, shift_amt, carry_in);
      endcase
      b   = pc_rel ? (pc_val & 32'hFFFF_FFFC) : base_val;
      sum = add_en ? b + ofs : b - ofs;
      acc = (pre_index && !unpriv) ? sum : b;
      wbe = cond_pass && (wb_req || unpriv) && !pc_rel;
      in_valid = 1'b1;
      @(negedge clk);
      in_valid = 1'b0;
      check(out_valid == 1'b1, {tag, " R11 out_valid"}, 32'(out_valid), 32'd1);
      check(acc_addr == acc, {tag, " acc_addr"}, acc_addr, acc);
      check(acc_addr_hi == acc + 32'd4, {tag, " R10 acc_addr_hi"}, acc_addr_hi, acc + 32'd4);
      check(wb_value == sum, {tag, " R4 wb_value"}, wb_value, sum);
      check(wb_en == wbe, {tag, " wb_en"}, 32'(wb_en), 32'(wbe));
   endtask

   task automatic clear_ctl();
      cond_pass = 1'b1; off_sel = 2'd0; shift_type = 2'd0; shift_rrx = 1'b0;
      shift_amt = '0; carry_in = 1'b0; add_en = 1'b1; pre_index = 1'b1;
      wb_req = 1'b0; pc_rel = 1'b0; unpriv = 1'b0;
   endtask

   initial begin
      logic [31:0] held;
      // R1 reset state
      repeat (3) @(negedge clk);
      check(out_valid == 1'b0, "R1 out_valid in reset", 32'(out_valid), 32'd0);
      check(wb_en == 1'b0, "R1 wb_en in reset", 32'(wb_en), 32'd0);
      rst_n = 1'b1;
      @(negedge clk);
      check(out_valid == 1'b0, "R1 out_valid after reset", 32'(out_valid), 32'd0);
      check(wb_en == 1'b0, "R1 wb_en after reset", 32'(wb_en), 32'd0);

      // R7 sweep of all shift kinds and amounts
      clear_ctl();
      off_sel = 2'd2;
      base_val = 32'h1000_0000;
      for (int k = 0; k < 4; k++) begin
         for (int a = 0; a < 32; a++) begin
            for (int v = 0; v < 2; v++) begin
               shift_type = 2'(k);
               shift_amt  = 5'(a);
               reg_val    = (v == 0) ? 32'h8000_00F1 : 32'h1234_5678;
               carry_in   = 1'(a);
               fire("R7 shift");
            end
         end
      end

      // R8 rotate through carry, type and amount ignored
      shift_rrx = 1'b1;
      for (int c = 0; c < 2; c++) begin
         for (int k = 0; k < 4; k++) begin
            carry_in = 1'(c); shift_type = 2'(k); shift_amt = 5'(k * 7 + 3);
            reg_val = 32'hA5A5_0003;
            fire("R8 rrx");
         end
      end

      // R2 R3 R4 R5 all combinations, including wraparound
      clear_ctl();
      for (int m = 0; m < 16; m++) begin
         for (int p = 0; p < 3; p++) begin
            add_en = m[0]; pre_index = m[1]; wb_req = m[2]; cond_pass = m[3];
            case (p)
               0: begin base_val = 32'hFFFF_FFF0; imm_val = 32'h0000_0020; end
               1: begin base_val = 32'h0000_0010; imm_val = 32'h0000_0020; end
               default: begin base_val = 32'h4000_1234; imm_val = 32'h0000_0FFF; end
            endcase
            fire("R2 R3 R4 R5 combo");
         end
      end

      // R12 offset source select
      clear_ctl();
      base_val = 32'h0000_8000; imm_val = 32'h0000_0100; reg_val = 32'h0000_0044;
      shift_type = 2'd0; shift_amt = 5'd4;
      for (int s = 0; s < 4; s++) begin
         off_sel = 2'(s);
         fire("R12 off_sel");
      end

      // R6 PC-relative base alignment, no writeback
      clear_ctl();
      base_val = 32'hDEAD_0000; imm_val = 32'h0000_0010; wb_req = 1'b1;
      pc_rel = 1'b1;
      for (int q = 0; q < 16; q++) begin
         pc_val = 32'h0000_2000 + 32'(q);
         add_en = q[2]; pre_index = q[3];
         fire("R6 pc_rel");
      end

      // R9 unprivileged forces post-index and writeback
      clear_ctl();
      unpriv = 1'b1; base_val = 32'h0002_0000; imm_val = 32'h0000_0030;
      for (int u = 0; u < 4; u++) begin
         pre_index = u[0]; wb_req = u[1];
         fire("R9 unpriv");
      end

      // R11 idle cycle: valid drops, outputs hold
      clear_ctl();
      base_val = 32'h0000_1000; imm_val = 32'h8;
      fire("R11 setup");
      held = acc_addr;
      base_val = 32'h7777_0000;
      @(negedge clk);
      check(out_valid == 1'b0, "R11 out_valid idle", 32'(out_valid), 32'd0);
      check(acc_addr == held, "R11 acc_addr held", acc_addr, held);
      check(wb_en == 1'b0, "R11 wb_en idle", 32'(wb_en), 32'd0);
      done = 1'b1;
   end

   initial begin
      for (int w = 0; w < 20000; w++) begin
         @(negedge clk);
         if (done) break;
      end
      if (!done) begin
         n_tests++;
         n_fail++;
         $display("FAIL watchdog expired");
      end
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

endmodule